// File: doc/BRIEF.md
# Maskable Interrupt Flag Controller

This block gathers single-cycle event pulses from a receiver datapath into a byte of sticky flags. Each flag stays set until the bus interface reports the particular access that consumes it. The consuming access is either a completed bulk data read, a read of the status register, or a read of the frame-info register. A write-one-to-clear scheme is not used.

A per-bit enable mask selects which flags may pull the active-low interrupt line. The line is also pulled low while the interface waits for the payload half of a two-part command. When a bus transaction completes, the line is released high for at least one cycle. This gives the host a fresh falling edge whenever something is still pending.

A second tier of extended flags has its own mask. Any extended flag that is both enabled and pending shows up as a single summary bit in the primary byte. The top bit of that byte mirrors a live busy input and is not stored.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, all stored flags, the primary mask, the extended mask and the extended flags are 0, and `irq_n_o` is 1.
- R2: A pulse on `evt_i[b]` (b = 0..5) sets `flags_o[b]` from the next clock edge on. The bit then holds until its clear strobe arrives. The bit positions are: 0 frame received, 1 stream lost, 2 window data changed, 3 link changed, 4 alternate start code frame, 5 identify changed.
- R3: `clr_bulk_i` clears flag bits 0 and 2 and no other bit.
- R4: `clr_status_i` clears flag bits 1, 3 and 5 and no other bit.
- R5: `clr_finfo_i` clears flag bit 4 and no other bit.
- R6: If an event arrives in the same cycle as the clear for its flag, the flag is left set. This applies to both primary and extended flags.
- R7: `flags_o[7]` equals `busy_i` in the same cycle and stores nothing.
- R8: `ext_evt_i[j]` sets `ext_flags_o[j]` at the next edge, and `ext_clr_i[j]` clears it. `flags_o[6]` is 1 exactly when some bit of `ext_flags_o` is set and its extended mask bit is also set. The extended mask is loaded by `ext_mask_wr_i`.
- R9: When `xfer_done_i` is low, `irq_n_o` at the next edge is 0 in either of two cases: `payload_wait_i` is high, or (`flags_o[6:0]` AND mask) is nonzero. Otherwise it is 1.
- R10: `xfer_done_i` forces `irq_n_o` to 1 at the next edge, whatever is pending.
- R11: `mask_wr_i` loads `mask_wdata_i` into the primary mask at the next edge. Mask bit k enables flag bit k, for k = 0..6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 6 | Primary event pulses, bit positions as in R2 |
| ext_evt_i | input | EXT_W | Extended event pulses (bit 0: request available) |
| busy_i | input | 1 | Live busy indication |
| mask_wr_i | input | 1 | Primary mask write strobe |
| mask_wdata_i | input | 7 | Primary mask write data |
| ext_mask_wr_i | input | 1 | Extended mask write strobe |
| ext_mask_wdata_i | input | EXT_W | Extended mask write data |
| clr_bulk_i | input | 1 | Bulk data read completed |
| clr_status_i | input | 1 | Status register read |
| clr_finfo_i | input | 1 | Frame-info register read |
| ext_clr_i | input | EXT_W | Per-bit extended clear (matching read or timeout) |
| xfer_done_i | input | 1 | Bus transaction completed |
| payload_wait_i | input | 1 | Command payload awaited |
| flags_o | output | 8 | Primary flag byte |
| irq_n_o | output | 1 | Active-low interrupt request |
| ext_flags_o | output | EXT_W | Extended flag word |

## Verification
The properties assume that all inputs are synchronous to `clk` and are applied between edges. They also assume that a strobe counts as seen only in a cycle when it is high at the edge. Nothing requires the clear strobes to be exclusive of each other, or `xfer_done_i` to be exclusive of `payload_wait_i`. For that reason the bench drives them together in some cycles.

The stimulus changes inputs only on the falling clock edge and holds each strobe for exactly one cycle. It reads the outputs on the next falling edge, one register stage after the strobe. The interrupt line sits a further stage later, and the bench reads it one cycle after that.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int NUM_EVT   = 6;
  localparam int MASK_W    = NUM_EVT + 1;
  localparam int FLAG_W    = 8;
  localparam int BIT_FRAME = 0;
  localparam int BIT_LOST  = 1;
  localparam int BIT_WCHG  = 2;
  localparam int BIT_LINK  = 3;
  localparam int BIT_ALTSC = 4;
  localparam int BIT_IDENT = 5;
  localparam int BIT_EXT   = 6;
  localparam int BIT_BUSY  = 7;

  // Map the three consuming accesses onto the flag bits they clear.
  function automatic logic [NUM_EVT-1:0] clear_vector(input logic bulk,
                                                      input logic status,
                                                      input logic finfo);
    logic [NUM_EVT-1:0] v;
    v = '0;
    v[BIT_FRAME] = bulk;
    v[BIT_WCHG]  = bulk;
    v[BIT_LOST]  = status;
    v[BIT_LINK]  = status;
    v[BIT_IDENT] = status;
    v[BIT_ALTSC] = finfo;
    return v;
  endfunction

  // Sticky update: the set term wins over the clear term.
  function automatic logic [31:0] sticky_next(input logic [31:0] cur,
                                              input logic [31:0] set,
                                              input logic [31:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/irqf_sticky.sv
module irqf_sticky #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [31:0] nxt;

  always_comb begin
    nxt = irqf_pkg::sticky_next(32'(q_o), 32'(set_i), 32'(clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= nxt[W-1:0];
  end
endmodule

// File: rtl/irqf_loadreg.sv
module irqf_loadreg #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= '0;
    else if (wr_i) q_o <= d_i;
  end
endmodule

// File: rtl/irqf_irq_gen.sv
module irqf_irq_gen #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] mask_i,
  input  logic         wait_i,
  input  logic         done_i,
  output logic         pend_o,
  output logic         irq_n_o
);
  assign pend_o = |(flags_i & mask_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_n_o <= 1'b1;
    else if (done_i) irq_n_o <= 1'b1;
    else             irq_n_o <= ~(pend_o | wait_i);
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
  parameter int EXT_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [irqf_pkg::NUM_EVT-1:0] evt_i,
  input  logic [EXT_W-1:0]           ext_evt_i,
  input  logic                       busy_i,
  input  logic                       mask_wr_i,
  input  logic [irqf_pkg::MASK_W-1:0] mask_wdata_i,
  input  logic                       ext_mask_wr_i,
  input  logic [EXT_W-1:0]           ext_mask_wdata_i,
  input  logic                       clr_bulk_i,
  input  logic                       clr_status_i,
  input  logic                       clr_finfo_i,
  input  logic [EXT_W-1:0]           ext_clr_i,
  input  logic                       xfer_done_i,
  input  logic                       payload_wait_i,
  output logic [irqf_pkg::FLAG_W-1:0] flags_o,
  output logic                       irq_n_o,
  output logic [EXT_W-1:0]           ext_flags_o
);
  import irqf_pkg::*;

  logic [NUM_EVT-1:0] clr_vec;
  logic [NUM_EVT-1:0] prim_q;
  logic [MASK_W-1:0]  mask_q;
  logic [EXT_W-1:0]   ext_mask_q;
  logic               ext_sum;
  logic               pend_w;

  assign clr_vec = clear_vector(clr_bulk_i, clr_status_i, clr_finfo_i);

  irqf_sticky #(.W(NUM_EVT)) u_prim (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr_vec), .q_o(prim_q)
  );

  irqf_sticky #(.W(EXT_W)) u_ext (
    .clk(clk), .rst_n(rst_n), .set_i(ext_evt_i), .clr_i(ext_clr_i), .q_o(ext_flags_o)
  );

  irqf_loadreg #(.W(MASK_W)) u_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(mask_wr_i), .d_i(mask_wdata_i), .q_o(mask_q)
  );

  irqf_loadreg #(.W(EXT_W)) u_ext_mask (
    .clk(clk), .rst_n(rst_n), .wr_i(ext_mask_wr_i), .d_i(ext_mask_wdata_i),
    .q_o(ext_mask_q)
  );

  assign ext_sum = |(ext_flags_o & ext_mask_q);

  assign flags_o = {busy_i, ext_sum, prim_q};

  irqf_irq_gen #(.W(MASK_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .flags_i(flags_o[MASK_W-1:0]), .mask_i(mask_q),
    .wait_i(payload_wait_i), .done_i(xfer_done_i), .pend_o(pend_w),
    .irq_n_o(irq_n_o)
  );
endmodule

// File: rtl/irqf_chk.sv
module irqf_chk #(
  parameter int EXT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [5:0]       evt_i,
  input logic [EXT_W-1:0] ext_evt_i,
  input logic             mask_wr_i,
  input logic [6:0]       mask_wdata_i,
  input logic             clr_bulk_i,
  input logic             clr_status_i,
  input logic             clr_finfo_i,
  input logic             xfer_done_i,
  input logic             payload_wait_i,
  input logic [7:0]       flags_o,
  input logic             irq_n_o,
  input logic [EXT_W-1:0] ext_flags_o,
  input logic [6:0]       mask_q,
  input logic [EXT_W-1:0] ext_mask_q
);
  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i != 0) |=> ((flags_o[5:0] & $past(evt_i)) == $past(evt_i))); // R6
  AST_NO_ACTIVITY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i == 0 && !clr_bulk_i && !clr_status_i && !clr_finfo_i)
      |=> $stable(flags_o[5:0])); // R2
  AST_BULK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_bulk_i && !evt_i[0] && !evt_i[2]) |=> (!flags_o[0] && !flags_o[2])); // R3
  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status_i && !evt_i[1] && !evt_i[3] && !evt_i[5])
      |=> (!flags_o[1] && !flags_o[3] && !flags_o[5])); // R4
  AST_FINFO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_finfo_i && !evt_i[4]) |=> !flags_o[4]); // R5
  AST_EXT_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    flags_o[6] == ((ext_flags_o & ext_mask_q) != 0)); // R8
  AST_EXT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_evt_i != 0) |=> ((ext_flags_o & $past(ext_evt_i)) == $past(ext_evt_i))); // R8
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done_i |=> irq_n_o); // R10
  AST_WAIT_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (!xfer_done_i && payload_wait_i) |=> !irq_n_o); // R9
  AST_QUIET_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (!payload_wait_i && ((flags_o[6:0] & mask_q) == 0)) |=> irq_n_o); // R9
  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_i |=> (mask_q == $past(mask_wdata_i))); // R11
endmodule

bind irq_flag_ctrl irqf_chk #(.EXT_W(EXT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ext_evt_i(ext_evt_i),
  .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
  .clr_bulk_i(clr_bulk_i), .clr_status_i(clr_status_i), .clr_finfo_i(clr_finfo_i),
  .xfer_done_i(xfer_done_i), .payload_wait_i(payload_wait_i),
  .flags_o(flags_o), .irq_n_o(irq_n_o), .ext_flags_o(ext_flags_o),
  .mask_q(mask_q), .ext_mask_q(ext_mask_q)
);

// File: tb/sim_irq_flag_ctrl.sv
`timescale 1ns/1ps
module sim_irq_flag_ctrl;
  localparam int EXT_W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] evt_i = '0;
  logic [EXT_W-1:0] ext_evt_i = '0;
  logic busy_i = 1'b0;
  logic mask_wr_i = 1'b0;
  logic [6:0] mask_wdata_i = '0;
  logic ext_mask_wr_i = 1'b0;
  logic [EXT_W-1:0] ext_mask_wdata_i = '0;
  logic clr_bulk_i = 1'b0, clr_status_i = 1'b0, clr_finfo_i = 1'b0;
  logic [EXT_W-1:0] ext_clr_i = '0;
  logic xfer_done_i = 1'b0, payload_wait_i = 1'b0;
  logic [7:0] flags_o;
  logic irq_n_o;
  logic [EXT_W-1:0] ext_flags_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  irq_flag_ctrl #(.EXT_W(EXT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .ext_evt_i(ext_evt_i), .busy_i(busy_i),
    .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
    .ext_mask_wr_i(ext_mask_wr_i), .ext_mask_wdata_i(ext_mask_wdata_i),
    .clr_bulk_i(clr_bulk_i), .clr_status_i(clr_status_i), .clr_finfo_i(clr_finfo_i),
    .ext_clr_i(ext_clr_i), .xfer_done_i(xfer_done_i), .payload_wait_i(payload_wait_i),
    .flags_o(flags_o), .irq_n_o(irq_n_o), .ext_flags_o(ext_flags_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic nxt();
    @(negedge clk);
  endtask

  task automatic clr_kind(input int k);
    clr_bulk_i   = (k == 0);
    clr_status_i = (k == 1);
    clr_finfo_i  = (k == 2);
  endtask

  task automatic clear_all();
    clr_bulk_i = 1; clr_status_i = 1; clr_finfo_i = 1; ext_clr_i = '1;
    nxt();
    clr_bulk_i = 0; clr_status_i = 0; clr_finfo_i = 0; ext_clr_i = '0;
    nxt();
  endtask

  task automatic set_mask(input logic [6:0] m);
    mask_wr_i = 1; mask_wdata_i = m;
    nxt();
    mask_wr_i = 0;
  endtask

  function automatic bit group_hit(input int b, input int k);
    if (k == 0) return (b == 0 || b == 2);
    if (k == 1) return (b == 1 || b == 3 || b == 5);
    return (b == 4);
  endfunction

  initial begin
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) nxt();
    rst_n = 1;
    nxt();
    // R1 reset state
    chk("R1 flags", 32'(flags_o), 0);
    chk("R1 ext", 32'(ext_flags_o), 0);
    chk("R1 irq", 32'(irq_n_o), 1);

    // R2/R3/R4/R5: every flag against every clear kind
    set_mask(7'h7F);
    for (int b = 0; b < 6; b++) begin
      for (int k = 0; k < 3; k++) begin
        evt_i = 6'(1 << b);
        nxt();
        evt_i = '0;
        chk("R2 set", 32'(flags_o[5:0]), 32'(1 << b));
        nxt();
        chk("R9 pend irq", 32'(irq_n_o), 0);
        clr_kind(k);
        nxt();
        clr_kind(3);
        if (k == 0) chk("R3 bulk", 32'(flags_o[b]), group_hit(b, k) ? 0 : 1);
        else if (k == 1) chk("R4 status", 32'(flags_o[b]), group_hit(b, k) ? 0 : 1);
        else chk("R5 finfo", 32'(flags_o[b]), group_hit(b, k) ? 0 : 1);
        clear_all();
      end
    end

    // R3/R4/R5: all flags set, one clear kind, remaining pattern computed
    for (int k = 0; k < 3; k++) begin
      logic [5:0] exp;
      exp = '0;
      for (int b = 0; b < 6; b++) exp[b] = !group_hit(b, k);
      evt_i = 6'h3F;
      nxt();
      evt_i = '0;
      clr_kind(k);
      nxt();
      clr_kind(3);
      chk(k == 0 ? "R3 group" : (k == 1 ? "R4 group" : "R5 group"),
          32'(flags_o[5:0]), 32'(exp));
      clear_all();
    end

    // R6: event and its own clear in the same cycle
    for (int b = 0; b < 6; b++) begin
      int k;
      k = (b == 0 || b == 2) ? 0 : ((b == 4) ? 2 : 1);
      evt_i = 6'(1 << b);
      clr_kind(k);
      nxt();
      evt_i = '0;
      clr_kind(3);
      chk("R6 same cycle", 32'(flags_o[b]), 1);
      clear_all();
    end

    // R7 busy follows live input
    busy_i = 1; #1;
    chk("R7 busy high", 32'(flags_o[7]), 1);
    busy_i = 0; #1;
    chk("R7 busy low", 32'(flags_o[7]), 0);

    // R11/R9: mask sweep per flag
    for (int b = 0; b < 6; b++) begin
      for (int m = 0; m < 128; m++) begin
        set_mask(7'(m));
        evt_i = 6'(1 << b);
        nxt();
        evt_i = '0;
        nxt();
        chk("R11 mask gate", 32'(irq_n_o), ((m >> b) & 1) ? 0 : 1);
        clear_all();
      end
    end

    // R8: extended flags and summary over every extended mask
    set_mask(7'h40);
    for (int j = 0; j < EXT_W; j++) begin
      for (int m = 0; m < (1 << EXT_W); m++) begin
        ext_mask_wr_i = 1; ext_mask_wdata_i = EXT_W'(m);
        ext_evt_i = EXT_W'(1 << j);
        nxt();
        ext_mask_wr_i = 0; ext_evt_i = '0;
        chk("R8 ext set", 32'(ext_flags_o), 32'(1 << j));
        chk("R8 summary", 32'(flags_o[6]), (m >> j) & 1);
        nxt();
        chk("R8 summary irq", 32'(irq_n_o), ((m >> j) & 1) ? 0 : 1);
        ext_clr_i = EXT_W'(1 << j);
        nxt();
        ext_clr_i = '0;
        chk("R8 ext clr", 32'(ext_flags_o), 0);
        chk("R8 summary clr", 32'(flags_o[6]), 0);
        nxt();
      end
    end
    ext_evt_i = 1; ext_clr_i = 1;
    nxt();
    ext_evt_i = '0; ext_clr_i = '0;
    chk("R6 ext same cycle", 32'(ext_flags_o[0]), 1);
    clear_all();

    // R10: transaction end releases, then re-asserts
    set_mask(7'h7F);
    evt_i = 6'h01;
    nxt();
    evt_i = '0;
    nxt();
    chk("R9 pending low", 32'(irq_n_o), 0);
    xfer_done_i = 1;
    nxt();
    xfer_done_i = 0;
    chk("R10 release", 32'(irq_n_o), 1);
    nxt();
    chk("R10 reassert", 32'(irq_n_o), 0);
    clear_all();

    // R9/R10: payload wait alone
    set_mask(7'h00);
    nxt();
    chk("R9 quiet", 32'(irq_n_o), 1);
    payload_wait_i = 1;
    nxt();
    chk("R9 payload wait", 32'(irq_n_o), 0);
    xfer_done_i = 1;
    nxt();
    xfer_done_i = 0;
    chk("R10 wait release", 32'(irq_n_o), 1);
    payload_wait_i = 0;
    nxt();
    chk("R9 wait gone", 32'(irq_n_o), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule